// File: doc/BRIEF.md
# Synthesizer Serial Programming Front End

This block receives configuration words for a fractional-N frequency synthesizer over a three-wire serial link made of a shift clock, a data line and a load strobe. The three lines are resynchronised to the system clock. Each rising edge of the shift clock moves one data bit into a 24-bit shift register, starting with the least significant bit. When the strobe rises, the two most significant bits select which register set takes the word: the divider word, the control word or the test word. The decoded fields are held as parallel outputs for the divider, pump and lock logic.

The fractional compensation code carried in the control word does not take effect at once. It waits in a shadow register and moves to its output only when the next divider word is loaded, so that it changes together with the new divider ratio. A divider word also opens a charge-pump speed-up window, which stays open until the strobe goes low. A bit in the test word can hold speed-up on permanently. The effective power-up signal combines the hardware power pin with the software power bit through an exclusive OR.

Top module: `synth_prog_if`

## Requirements
- R1: After reset the outputs are: divider ratio 1024, fractional increment 0, modulo-8 mode (mod5_sel = 0), reference ratio 100, push-pull lock mode (lock_od = 0), software power bit 1, pump ratio 0, compensation code 0, test bits 0 and speed-up 0.
- R2: A word is 24 bits, shifted in from bit 0 to bit 23. When bits 23:22 are 00 the word is a divider word: bit 21 sets mod5_sel (1 = modulo 5), bits 20:18 set nf_inc and bits 17:2 set n_div. Bits 1:0 are not used.
- R3: When bits 23:22 are 01 the word is a control word: bits 21:12 set r_div, bit 11 sets lock_od (1 = open drain), bit 10 is the software power bit, bit 9 sets pump_ratio and bits 8:1 are the compensation code. Bit 0 is not used.
- R4: A control word does not change fc_code. Its compensation code is stored in a shadow register and appears on fc_code when the next divider word loads, in the same cycle as the new n_div.
- R5: A word with address bits 10 has no effect on any output. The same holds when fewer than 24 shift clocks have arrived since the last strobe rise.
- R6: While the strobe is high, shift clock edges do not change the shift register and do not count toward the next word.
- R7: Loading a divider word drives speed_up high, and it stays high until the strobe goes low. Loading a control word does not drive speed_up high.
- R8: When bits 23:22 are 11 the word is a test word, and bits 21:0 appear on test_bits. While test bit 16 is 1, speed_up is high whatever the strobe does.
- R9: power_up equals pon_pin XOR the software power bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_data | input | 1 | Serial data, bit 0 first |
| ser_strobe | input | 1 | Load strobe, word decoded on rising edge |
| pon_pin | input | 1 | Hardware power pin |
| n_div | output | 16 | Main divider ratio |
| nf_inc | output | 3 | Fractional increment |
| mod5_sel | output | 1 | 1 selects modulo 5, 0 selects modulo 8 |
| r_div | output | 10 | Reference divider ratio |
| pump_ratio | output | 1 | Charge pump current ratio bit |
| lock_od | output | 1 | Lock output mode, 1 = open drain |
| power_up | output | 1 | Effective power-up |
| fc_code | output | 8 | Committed fractional compensation code |
| test_bits | output | 22 | Test word contents |
| speed_up | output | 1 | Charge pump speed-up request |

## Verification
Each word type is sent with distinct, asymmetric field values. A swapped, shifted or reversed bit therefore lands in the wrong field and shows up as a wrong value. The compensation code is checked in three steps: after reset, after a control word (where it must not change) and after the following divider word (where it must take the new value). This separates a shadowed commit from an immediate one. Several sequences must leave every output unchanged: an unused address, a truncated shift, and shift clocks sent while the strobe is high followed by a bare strobe. Speed-up is sampled while the strobe is high and again after it falls, for divider words, control words and the forcing test bit.

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
  parameter logic [15:0] N_RST = 16'd1024,
  parameter logic [9:0]  R_RST = 10'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_strobe,
  input  logic        pon_pin,
  output logic [15:0] n_div,
  output logic [2:0]  nf_inc,
  output logic        mod5_sel,
  output logic [9:0]  r_div,
  output logic        pump_ratio,
  output logic        lock_od,
  output logic        power_up,
  output logic [7:0]  fc_code,
  output logic [21:0] test_bits,
  output logic        speed_up
);
  localparam int WORD_W = 24;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [2:0] ck_q, stb_q;
  logic [1:0] dat_q;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic [7:0] fc_shadow;
  logic main_pwr, sup_win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0; stb_q <= '0; dat_q <= '0;
    end else begin
      ck_q  <= {ck_q[1:0], ser_clk};
      stb_q <= {stb_q[1:0], ser_strobe};
      dat_q <= {dat_q[0], ser_data};
    end

  wire ck_rise  = ck_q[1] & ~ck_q[2];
  wire stb_hi   = stb_q[1];
  wire stb_rise = stb_q[1] & ~stb_q[2];
  wire stb_fall = ~stb_q[1] & stb_q[2];
  wire full     = (cnt == CNT_W'(WORD_W));
  wire a_load   = stb_rise & full & (sr[23:22] == 2'b00);
  wire b_load   = stb_rise & full & (sr[23:22] == 2'b01);
  wire d_load   = stb_rise & full & (sr[23:22] == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; cnt <= '0;
    end else if (stb_rise) begin
      cnt <= '0;
    end else if (ck_rise && !stb_hi) begin
      sr <= {dat_q[1], sr[WORD_W-1:1]};
      if (!full) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_div <= N_RST; nf_inc <= '0; mod5_sel <= 1'b0; fc_code <= '0;
      r_div <= R_RST; lock_od <= 1'b0; main_pwr <= 1'b1; pump_ratio <= 1'b0;
      fc_shadow <= '0; test_bits <= '0;
    end else begin
      if (a_load) begin
        mod5_sel <= sr[21];
        nf_inc   <= sr[20:18];
        n_div    <= sr[17:2];
        fc_code  <= fc_shadow;
      end
      if (b_load) begin
        r_div      <= sr[21:12];
        lock_od    <= sr[11];
        main_pwr   <= sr[10];
        pump_ratio <= sr[9];
        fc_shadow  <= sr[8:1];
      end
      if (d_load) test_bits <= sr[21:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sup_win <= 1'b0;
    else if (a_load)   sup_win <= 1'b1;
    else if (stb_fall) sup_win <= 1'b0;

  assign speed_up = sup_win | test_bits[16];
  assign power_up = pon_pin ^ main_pwr;

  assert_fc_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fc_code) |-> $past(a_load));
  assert_ndiv_only_on_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_div) |-> $past(a_load));
  assert_rdiv_only_on_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_div) |-> $past(b_load));
  assert_frozen_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_hi && !stb_rise) |=> $stable(sr));
  assert_window_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> !sup_win);
  assert_window_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_load |=> speed_up);
endmodule

// File: tb/tb_synth_prog_if.sv
module tb_synth_prog_if;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_strobe = 0, pon_pin = 0;
  logic [15:0] n_div; logic [2:0] nf_inc; logic mod5_sel; logic [9:0] r_div;
  logic pump_ratio, lock_od, power_up, speed_up; logic [7:0] fc_code; logic [21:0] test_bits;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_prog_if dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .pon_pin(pon_pin), .n_div(n_div), .nf_inc(nf_inc),
    .mod5_sel(mod5_sel), .r_div(r_div), .pump_ratio(pump_ratio), .lock_od(lock_od),
    .power_up(power_up), .fc_code(fc_code), .test_bits(test_bits), .speed_up(speed_up));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [23:0] w, int nb);
    for (int i = 0; i < nb; i++) begin
      ser_data = w[i]; wait_clk(4);
      ser_clk = 1; wait_clk(4);
      ser_clk = 0; wait_clk(4);
    end
  endtask

  task automatic strobe_hi; ser_strobe = 1; wait_clk(8); endtask
  task automatic strobe_lo; ser_strobe = 0; wait_clk(8); endtask

  function automatic logic [23:0] mk_a(logic fm, logic [2:0] nf, logic [15:0] n);
    return {2'b00, fm, nf, n, 2'b00};
  endfunction
  function automatic logic [23:0] mk_b(logic [9:0] r, logic lo, logic pd, logic cp, logic [7:0] fc);
    return {2'b01, r, lo, pd, cp, fc, 1'b0};
  endfunction

  task automatic test_reset;
    chk("R1 n_div", n_div, 1024); chk("R1 nf_inc", nf_inc, 0); chk("R1 mod5", mod5_sel, 0);
    chk("R1 r_div", r_div, 100); chk("R1 lock_od", lock_od, 0); chk("R1 pump", pump_ratio, 0);
    chk("R1 fc", fc_code, 0); chk("R1 test", test_bits, 0); chk("R1 speed_up", speed_up, 0);
    chk("R1 power_up", power_up, 1);
  endtask

  task automatic test_a_word;
    shift_bits(mk_a(1'b1, 3'd5, 16'hBEEF), 24);
    strobe_hi;
    chk("R7 speed_up in window", speed_up, 1);
    chk("R2 n_div", n_div, 16'hBEEF); chk("R2 nf_inc", nf_inc, 5); chk("R2 mod5", mod5_sel, 1);
    strobe_lo;
    chk("R7 speed_up after fall", speed_up, 0);
  endtask

  task automatic test_b_word;
    shift_bits(mk_b(10'h2A5, 1'b1, 1'b1, 1'b1, 8'hA7), 24);
    strobe_hi;
    chk("R7 no speed_up for B", speed_up, 0);
    strobe_lo;
    chk("R3 r_div", r_div, 10'h2A5); chk("R3 lock_od", lock_od, 1);
    chk("R3 pump", pump_ratio, 1); chk("R9 power_up pon0 pd1", power_up, 1);
    chk("R4 fc held", fc_code, 0);
    chk("R4 n_div untouched", n_div, 16'hBEEF);
  endtask

  task automatic test_commit;
    shift_bits(mk_a(1'b0, 3'd3, 16'h1234), 24);
    strobe_hi; strobe_lo;
    chk("R4 fc committed", fc_code, 8'hA7); chk("R2 n_div 2", n_div, 16'h1234);
    chk("R2 nf_inc 2", nf_inc, 3); chk("R2 mod5 2", mod5_sel, 0);
  endtask

  task automatic test_ignored;
    shift_bits({2'b10, 22'h3FFFFF}, 24);
    strobe_hi; strobe_lo;
    chk("R5 addr10 n_div", n_div, 16'h1234); chk("R5 addr10 r_div", r_div, 10'h2A5);
    chk("R5 addr10 test", test_bits, 0); chk("R5 addr10 lock", lock_od, 1);
    shift_bits(mk_a(1'b1, 3'd7, 16'h5555), 20);
    strobe_hi;
    chk("R5 short no speed_up", speed_up, 0);
    strobe_lo;
    chk("R5 short n_div", n_div, 16'h1234); chk("R5 short nf_inc", nf_inc, 3);
  endtask

  task automatic test_frozen;
    shift_bits(mk_b(10'h155, 1'b0, 1'b1, 1'b0, 8'h3C), 24);
    strobe_hi;
    shift_bits(mk_b(10'h0AA, 1'b1, 1'b1, 1'b1, 8'hC3), 24);
    strobe_lo;
    chk("R3 r_div 2", r_div, 10'h155);
    strobe_hi; strobe_lo;
    chk("R6 frozen r_div", r_div, 10'h155); chk("R6 frozen lock", lock_od, 0);
    chk("R6 frozen pump", pump_ratio, 0);
  endtask

  task automatic test_d_word;
    shift_bits({2'b11, 22'h010021}, 24);
    strobe_hi; strobe_lo;
    chk("R8 test_bits", test_bits, 22'h010021);
    chk("R8 forced speed_up", speed_up, 1);
    shift_bits({2'b11, 22'h0}, 24);
    strobe_hi;
    chk("R8 cleared speed_up", speed_up, 0);
    strobe_lo;
    chk("R8 test_bits zero", test_bits, 0);
  endtask

  task automatic test_power;
    pon_pin = 1; wait_clk(2);
    chk("R9 pon1 pd1", power_up, 0);
    shift_bits(mk_b(10'h155, 1'b0, 1'b0, 1'b0, 8'h3C), 24);
    strobe_hi; strobe_lo;
    chk("R9 pon1 pd0", power_up, 1);
    pon_pin = 0; wait_clk(2);
    chk("R9 pon0 pd0", power_up, 0);
  endtask

  initial begin
    wait_clk(4); rst_n = 1; wait_clk(4);
    test_reset; test_a_word; test_b_word; test_commit; test_ignored;
    test_frozen; test_d_word; test_power;
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule